// File: doc/BRIEF.md
# Programmable TDM Slot Calendar

This block drives the time-division schedule of one bus segment. A table of up to 64 slots holds, for each slot, the index of the device position that owns it (0 to 12) or the idle code 13. While the calendar runs, one slot is presented per clock cycle. The slot pointer returns to slot 0 after it reaches the last programmed slot. A per-segment map translates the presented device position into a global port number and flags whether a real device sits there. Eight copies are placed in a chip, one per segment, and each copy is told its segment through the `SEGMENT` parameter.

Software loads a schedule through three register-style controls. It raises a program-enable level, then issues pairs of accesses: an index write that selects a slot, followed by a value write that fills that slot. It then drops program enable. The length of the calendar is never written directly. It follows from the highest slot index filled during the session, and it is reported as that index, which is the entry count minus one. Out of reset the calendar is a single idle slot.

The controller has two states. ST_RUN presents slots and advances the pointer. ST_PGM presents idle while the table is being written. The transition "enter" (ST_RUN to ST_PGM) is taken on any cycle where program enable is sampled high. The transition "commit" (ST_PGM to ST_RUN) is taken when program enable is sampled low; at that edge the new length is stored and the pointer restarts at slot 0. Reset places the controller in ST_RUN.

Top module: `tdm_slot_calendar`

## Requirements
- R1: After reset, slot_dev is 13, cur_len is 0 and slot_port_vld is 0. The calendar then runs as a single idle slot.
- R2: From the cycle after pgm_en is sampled high, and for as long as it stays high, slot_dev is the idle code 13.
- R3: A value write (val_wr=1 while pgm_en=1) stores val_in in the slot named by the most recent index write. If idx_wr and val_wr are both high in one cycle, the value goes to idx_in of that same cycle.
- R4: When pgm_en is sampled low after a session, cur_len becomes the highest slot index filled during that session, regardless of write order. A session with no value writes leaves cur_len unchanged.
- R5: In the cycle after pgm_en is sampled low, slot 0 is presented. The pointer then advances by one slot per clock and returns to slot 0 after slot cur_len.
- R6: idx_wr and val_wr are ignored while pgm_en is low, including in the cycle that ends a session. The stored schedule does not change.
- R7: Stored values 14 and 15 are presented as the idle code 13. slot_dev never exceeds 13.
- R8: slot_port is the port mapped to the presented position for the configured segment. slot_port_vld is 1 only when the position is 0..12, the map holds an entry there (the unused marker 99 does not count), and that port number is below 70. For segment 0 the map is positions 0..12 to ports 57, 12, 0, 1, 2, 16..23. For segment 6 it is positions 0..3 to ports 56, 63, 54, 55, with the rest unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pgm_en | input | 1 | Program enable level |
| idx_wr | input | 1 | Index write strobe |
| idx_in | input | 6 | Slot index to select |
| val_wr | input | 1 | Value write strobe |
| val_in | input | 4 | Slot value (device position or 13 for idle) |
| slot_dev | output | 4 | Device position owning the current slot, 13 when idle |
| slot_port | output | 7 | Global port of the current slot's device |
| slot_port_vld | output | 1 | slot_port names a real device |
| cur_len | output | 6 | Committed calendar length minus one |

## Verification
Two functions can fall in the same cycle, and the bench forces both cases. The first is an index write and a value write together: the bench fills a whole schedule using only combined strobes, then checks that each value landed at the index given in that same cycle. The second is the end of a session and a write that arrives with it: strobes are raised on the very cycle pgm_en falls. The bench then follows two full laps to confirm that slot 0 and cur_len did not change. The length sweep covers every calendar length from 1 to 64. For each length, the expected slot sequence, wrap point and port mapping are computed from a model of the table held in the bench.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef enum logic [0:0] {
        ST_RUN = 1'b0,
        ST_PGM = 1'b1
    } cal_state_e;

    localparam int unsigned MAP_UNUSED = 99;
    localparam int unsigned PORT_LIMIT = 70;

    // Position-to-port map, computed per segment.
    function automatic int unsigned pos_to_port(int unsigned seg, int unsigned pos);
        int unsigned p;
        p = MAP_UNUSED;
        if (seg < 4) begin
            if (pos == 0)       p = 57 + seg;
            else if (pos == 1)  p = 12 + seg;
            else if (pos < 5)   p = 3 * seg + pos - 2;
            else if (pos < 13)  p = 16 + 8 * seg + pos - 5;
        end else if (seg < 6) begin
            if (pos == 0)       p = 57 + seg;
            else if (pos < 4)   p = 48 + 3 * (seg - 4) + pos - 1;
        end else if (seg == 6) begin
            case (pos)
                0: p = 56;
                1: p = 63;
                2: p = 54;
                3: p = 55;
                default: p = MAP_UNUSED;
            endcase
        end else if (seg == 7) begin
            if (pos == 0) p = 64;
        end
        return p;
    endfunction

endpackage

// File: rtl/cal_slot_store.sv
module cal_slot_store #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned VAL_W = 4,
    parameter int unsigned IDLE  = 13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pgm_en,
    input  logic                     commit,
    input  logic                     idx_wr,
    input  logic [$clog2(DEPTH)-1:0] idx_in,
    input  logic                     val_wr,
    input  logic [VAL_W-1:0]         val_in,
    input  logic [$clog2(DEPTH)-1:0] rd_ptr,
    output logic [VAL_W-1:0]         rd_val,
    output logic [$clog2(DEPTH)-1:0] len_q
);
    localparam int unsigned IDX_W = $clog2(DEPTH);

    logic [VAL_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] max_q;
    logic             any_q;
    logic [IDX_W-1:0] wr_idx;
    logic             wr_go;

    // R3: a same-cycle index write takes precedence over the latched index.
    assign wr_idx = idx_wr ? idx_in : idx_q;
    assign wr_go  = pgm_en && val_wr;
    assign rd_val = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                mem[i] <= VAL_W'(IDLE);
            end
            idx_q <= '0;
            max_q <= '0;
            any_q <= 1'b0;
            len_q <= '0;
        end else begin
            if (pgm_en && idx_wr) begin
                idx_q <= idx_in;
            end
            if (wr_go) begin
                mem[wr_idx] <= val_in;
                any_q       <= 1'b1;
                if (!any_q || (wr_idx > max_q)) begin
                    max_q <= wr_idx;
                end
            end
            if (commit) begin
                if (any_q) begin
                    len_q <= max_q;
                end
                any_q <= 1'b0;
            end
        end
    end

    p_max_tracks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> (max_q >= $past(wr_idx)) && any_q);

    p_len_only_on_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(len_q));

    p_no_write_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pgm_en && !commit) |=> $stable(any_q));

endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
    import cal_pkg::*;
#(
    parameter int unsigned IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pgm_en,
    input  logic [IDX_W-1:0] len,
    output logic [IDX_W-1:0] ptr,
    output logic             in_pgm,
    output logic             commit
);
    cal_state_e       state_q, state_d;
    logic [IDX_W-1:0] ptr_q;

    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (pgm_en) state_d = ST_PGM;          // enter
            end
            ST_PGM: begin
                if (!pgm_en) begin                      // commit
                    state_d = ST_RUN;
                    commit  = 1'b1;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (state_q == ST_PGM || pgm_en) begin
            ptr_q <= '0;
        end else if (ptr_q == len) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign ptr    = ptr_q;
    assign in_pgm = (state_q == ST_PGM);

    p_ptr_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= len);

    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PGM && !pgm_en) |=> (ptr_q == '0) && (state_q == ST_RUN));

    p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !pgm_en && ptr_q != len) |=> ptr_q == $past(ptr_q) + 1'b1);

    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !pgm_en && ptr_q == len) |=> ptr_q == '0);

endmodule

// File: rtl/cal_port_map.sv
module cal_port_map
    import cal_pkg::*;
#(
    parameter int unsigned SEGMENT   = 0,
    parameter int unsigned POS_W     = 4,
    parameter int unsigned PORT_W    = 7,
    parameter int unsigned POSITIONS = 13
) (
    input  logic [POS_W-1:0]  pos,
    output logic [PORT_W-1:0] port,
    output logic              vld
);
    int unsigned raw;

    always_comb begin
        raw = pos_to_port(SEGMENT, int'(pos));
        vld = (int'(pos) < int'(POSITIONS)) && (raw < PORT_LIMIT);
        port = vld ? PORT_W'(raw) : '0;
    end

endmodule

// File: rtl/tdm_slot_calendar.sv
module tdm_slot_calendar
    import cal_pkg::*;
#(
    parameter int unsigned SEGMENT = 0,
    parameter int unsigned DEPTH   = 64,
    parameter int unsigned DEVICES = 13,
    parameter int unsigned VAL_W   = 4,
    parameter int unsigned PORT_W  = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pgm_en,
    input  logic                     idx_wr,
    input  logic [$clog2(DEPTH)-1:0] idx_in,
    input  logic                     val_wr,
    input  logic [VAL_W-1:0]         val_in,
    output logic [VAL_W-1:0]         slot_dev,
    output logic [PORT_W-1:0]        slot_port,
    output logic                     slot_port_vld,
    output logic [$clog2(DEPTH)-1:0] cur_len
);
    localparam int unsigned IDX_W = $clog2(DEPTH);
    localparam int unsigned IDLE  = DEVICES;

    logic [IDX_W-1:0] ptr;
    logic [VAL_W-1:0] rd_val;
    logic             in_pgm;
    logic             commit;

    cal_sequencer #(.IDX_W(IDX_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .pgm_en (pgm_en),
        .len    (cur_len),
        .ptr    (ptr),
        .in_pgm (in_pgm),
        .commit (commit)
    );

    cal_slot_store #(.DEPTH(DEPTH), .VAL_W(VAL_W), .IDLE(IDLE)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .pgm_en (pgm_en),
        .commit (commit),
        .idx_wr (idx_wr),
        .idx_in (idx_in),
        .val_wr (val_wr),
        .val_in (val_in),
        .rd_ptr (ptr),
        .rd_val (rd_val),
        .len_q  (cur_len)
    );

    // R2 / R7: idle while programming, out-of-range codes fold to idle.
    always_comb begin
        if (in_pgm || rd_val > VAL_W'(IDLE)) slot_dev = VAL_W'(IDLE);
        else                                 slot_dev = rd_val;
    end

    cal_port_map #(
        .SEGMENT   (SEGMENT),
        .POS_W     (VAL_W),
        .PORT_W    (PORT_W),
        .POSITIONS (DEVICES)
    ) u_map (
        .pos  (slot_dev),
        .port (slot_port),
        .vld  (slot_port_vld)
    );

    p_idle_while_pgm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_en |=> slot_dev == VAL_W'(IDLE));

    p_dev_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        slot_dev <= VAL_W'(IDLE));

    p_idle_no_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_dev == VAL_W'(IDLE)) |-> !slot_port_vld);

endmodule

// File: tb/sim_tdm_slot_calendar.sv
`timescale 1ns/1ps
module sim_tdm_slot_calendar;

    logic       clk = 1'b0;
    logic       rst_n, pgm_en, idx_wr, val_wr;
    logic [5:0] idx_in;
    logic [3:0] val_in;
    logic [3:0] dev0, dev1;
    logic [6:0] port0, port1;
    logic       vld0, vld1;
    logic [5:0] len0, len1;

    int checks = 0;
    int errors = 0;
    int model [64];
    int mlen;
    int hi;
    bit anyw;

    always #2.5 clk = ~clk;

    tdm_slot_calendar #(.SEGMENT(0)) u0 (
        .clk(clk), .rst_n(rst_n), .pgm_en(pgm_en), .idx_wr(idx_wr), .idx_in(idx_in),
        .val_wr(val_wr), .val_in(val_in), .slot_dev(dev0), .slot_port(port0),
        .slot_port_vld(vld0), .cur_len(len0));

    tdm_slot_calendar #(.SEGMENT(6)) u1 (
        .clk(clk), .rst_n(rst_n), .pgm_en(pgm_en), .idx_wr(idx_wr), .idx_in(idx_in),
        .val_wr(val_wr), .val_in(val_in), .slot_dev(dev1), .slot_port(port1),
        .slot_port_vld(vld1), .cur_len(len1));

    function automatic int seg0_port(int pos);
        case (pos)
            0: return 57;
            1: return 12;
            2: return 0;
            3: return 1;
            4: return 2;
            default: return pos + 11;
        endcase
    endfunction

    function automatic int seg6_port(int pos);
        case (pos)
            0: return 56;
            1: return 63;
            2: return 54;
            3: return 55;
            default: return -1;
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic note_write(int i, int v);
        model[i] = v;
        if (!anyw || i > hi) hi = i;
        anyw = 1;
    endtask

    task automatic pgm_start();
        pgm_en = 1'b1;
        anyw   = 0;
        @(negedge clk);
        chk("R2 dev0 idle on enter", dev0, 13);
        chk("R2 dev1 idle on enter", dev1, 13);
    endtask

    task automatic wr_sep(int i, int v);
        idx_wr = 1'b1; idx_in = 6'(i);
        @(negedge clk);
        idx_wr = 1'b0;
        chk("R2 idle during pgm", dev0, 13);
        val_wr = 1'b1; val_in = 4'(v);
        @(negedge clk);
        val_wr = 1'b0;
        chk("R2 idle during pgm", dev0, 13);
        note_write(i, v);
    endtask

    task automatic wr_both(int i, int v);
        idx_wr = 1'b1; idx_in = 6'(i);
        val_wr = 1'b1; val_in = 4'(v);
        @(negedge clk);
        idx_wr = 1'b0; val_wr = 1'b0;
        chk("R3 idle during combined write", dev0, 13);
        note_write(i, v);
    endtask

    task automatic pgm_end(bit poke);
        pgm_en = 1'b0;
        if (poke) begin
            idx_wr = 1'b1; val_wr = 1'b1;
            idx_in = 6'd0; val_in = 4'((model[0] + 5) % 13);
        end
        if (anyw) mlen = hi + 1;
    endtask

    task automatic run(int n, string tag);
        for (int k = 0; k < n; k++) begin
            int e;
            @(negedge clk);
            idx_wr = 1'b0; val_wr = 1'b0;
            e = model[k % mlen];
            if (e > 13) e = 13;
            chk({tag, " R5 slot sequence u0"}, dev0, e);
            chk({tag, " R5 slot sequence u1"}, dev1, e);
            if (k == 0) chk({tag, " R4 cur_len"}, len0, mlen - 1);
            chk({tag, " R8 vld seg0"}, vld0, (e < 13) ? 1 : 0);
            if (e < 13) chk({tag, " R8 port seg0"}, port0, seg0_port(e));
            chk({tag, " R8 vld seg6"}, vld1, (e < 4) ? 1 : 0);
            if (e < 4) chk({tag, " R8 port seg6"}, port1, seg6_port(e));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pgm_en = 1'b0; idx_wr = 1'b0; val_wr = 1'b0;
        idx_in = '0; val_in = '0;
        for (int i = 0; i < 64; i++) model[i] = 13;
        mlen = 1; hi = 0; anyw = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset dev", dev0, 13);
        chk("R1 reset len", len0, 0);
        chk("R1 reset vld", vld0, 0);
        rst_n = 1'b1;
        run(5, "R1");

        // Length sweep 1..64 with separate index/value writes.
        for (int L = 1; L <= 64; L++) begin
            pgm_start();
            for (int i = 0; i < L; i++) wr_sep(i, (i * 5 + L) % 16);
            pgm_end(0);
            run(2 * L + 2, "R5 sweep");
        end

        // R3: combined index and value writes.
        pgm_start();
        for (int i = 0; i < 7; i++) wr_both(i, (i + 3) % 14);
        pgm_end(0);
        run(16, "R3");

        // R6/R4: empty session, writes during exit cycle ignored.
        pgm_start();
        pgm_end(1);
        run(20, "R6");

        // R4: highest index wins over last-written index.
        pgm_start();
        wr_sep(9, 2);
        wr_sep(3, 7);
        pgm_end(0);
        run(25, "R4");

        // R7: codes above idle fold to idle.
        pgm_start();
        wr_both(0, 14);
        wr_both(1, 15);
        wr_both(2, 13);
        wr_both(3, 4);
        pgm_end(0);
        run(12, "R7");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule